// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block carries register writes from a bus clock domain into a timer clock domain that runs asynchronously to it. A write to one of the covered timer registers is latched on the bus side. A single toggle bit then announces the write to the timer side. The timer side presents the write for exactly one timer cycle and returns a toggle acknowledge. Once that acknowledge has been resynchronized into the bus domain, the block is free again. Between acceptance and acknowledge the block reports `busy`, and software polls this flag. A covered write that arrives while `busy` is set is dropped without notice. It is neither queued nor stalled.

Writes to addresses outside the covered set belong to registers kept in the bus domain. They are forwarded in the same cycle on a bypass output, and `busy` never blocks them. Both outputs are valid-only streams with no back-pressure. The timer-side register decode must consume `tm_valid` in the cycle it is high, and the bus-side registers must consume `pass_valid` in the cycle it is high. The write input is a plain strobe: there is no ready, and a dropped write is never retried by the block.

Top module: `wsync_xdom`

## Requirements
- R1: While either reset is asserted, and in the first cycles after release, `busy`, `tm_valid` and `pass_valid` are 0.
- R2: A write (`wr_en`=1) to a covered address, sampled while `busy` reads 0, is accepted, and `busy` reads 1 from the next bus cycle. A write issued in the first cycle where `busy` reads 0 is accepted.
- R3: A write to a covered address sampled while `busy` reads 1 is discarded. It never appears on `tm_valid`, it does not appear on the bypass output, and it does not change the `tm_addr`/`tm_data` value held for the pending write.
- R4: Each accepted write produces exactly one `tm_valid` pulse, one timer cycle long, carrying the accepted address and data on `tm_addr`/`tm_data`.
- R5: The `tm_valid` pulse is visible after exactly SYNC_STAGES rising timer clock edges that follow the bus edge which accepted the write. The default is 2 stages.
- R6: `busy` stays 1 until after the timer-side pulse has occurred. It then falls once the acknowledge toggle has passed SYNC_STAGES bus flops, so the whole busy period lies between SYNC_STAGES+1 and ((SYNC_STAGES+1)*Ttimer)/Tbus + SYNC_STAGES + 3 bus cycles.
- R7: A write to an address outside the covered set drives `pass_valid`=1 with `pass_addr`/`pass_data` equal to the inputs in the same cycle, whatever `busy` reads. It never sets `busy`.
- R8: Address a is covered when bit a of COVER is 1. By default the covered addresses are 0 to 10: control, counter value, status clear, wake enable, event enable, event disable, two periodic intervals, two alarms and tuner. Addresses 11 to 15 are uncovered and never produce a timer-side pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus interface clock |
| bus_rst_n | input | 1 | Bus domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | AW | Register word address of the write |
| wr_data | input | DW | Write data |
| busy | output | 1 | Synchronization in progress; covered writes are dropped while 1 |
| pass_valid | output | 1 | Uncovered write forwarded this cycle to bus-domain registers |
| pass_addr | output | AW | Address of the forwarded write |
| pass_data | output | DW | Data of the forwarded write |
| tmr_clk | input | 1 | Timer clock, asynchronous to bus_clk |
| tmr_rst_n | input | 1 | Timer domain asynchronous reset, active low |
| tm_valid | output | 1 | One-timer-cycle pulse delivering a synchronized write |
| tm_addr | output | AW | Address of the synchronized write, held stable while busy |
| tm_data | output | DW | Data of the synchronized write, held stable while busy |

## Verification
The bypass output is combinational and is checked one time unit after the strobe is driven. `busy` is registered and is checked at the falling bus edge after the accepting edge. The bench timestamps each accepted write by counting timer edges. It then requires every `tm_valid` pulse, sampled at the falling timer edge, to land exactly SYNC_STAGES timer edges later, and it requires the pulse never to be seen in two consecutive samples. The clock periods are chosen so that no rising edges coincide, so the busy period can be bounded and counted in bus cycles. After `busy` falls, the bench waits several cycles before comparing the pulse count and the delivered address and data against the sweep's arithmetic values.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

  // Word indices of the timer registers that must cross domains.
  typedef enum logic [3:0] {
    REG_CTRL   = 4'd0,
    REG_COUNT  = 4'd1,
    REG_STCLR  = 4'd2,
    REG_WAKE   = 4'd3,
    REG_EVON   = 4'd4,
    REG_EVOFF  = 4'd5,
    REG_PER0   = 4'd6,
    REG_PER1   = 4'd7,
    REG_ALM0   = 4'd8,
    REG_ALM1   = 4'd9,
    REG_TUNE   = 4'd10
  } tmr_reg_e;

  localparam int unsigned DEF_AW     = 4;
  localparam int unsigned DEF_DW     = 32;
  localparam int unsigned DEF_STAGES = 2;

  // Covered mask: every index up to the last timer register.
  function automatic logic [15:0] default_cover();
    logic [15:0] m;
    m = '0;
    for (int i = 0; i <= int'(REG_TUNE); i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [15:0] DEF_COVER = default_cover();

endpackage

// File: rtl/wsync_tog_sync.sv
// Multi-flop synchronizer for a single toggle bit.
module wsync_tog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/wsync_launch.sv
// Bus-side half: decodes coverage, accepts one write at a time, holds it
// until the returned acknowledge matches the request toggle.
module wsync_launch #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter logic [(1<<AW)-1:0] COVER = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_sync,
  output logic          busy,
  output logic          req_tog,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic          pass_valid,
  output logic [AW-1:0] pass_addr,
  output logic [DW-1:0] pass_data
);

  logic hit;
  logic accept;
  logic pend_q;
  logic req_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign hit    = COVER[wr_addr];
  assign accept = wr_en & hit & ~pend_q;

  // Pending flag: set on acceptance, cleared when the acknowledge toggle
  // has caught up with the request toggle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      req_q  <= ~req_q;
    end else if (pend_q && (ack_sync == req_q)) begin
      pend_q <= 1'b0;
    end
  end

  // Captured write, frozen for the whole pending interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign busy      = pend_q;
  assign req_tog   = req_q;
  assign hold_addr = addr_q;
  assign hold_data = data_q;

  // Uncovered writes bypass the crossing entirely.
  assign pass_valid = wr_en & ~hit;
  assign pass_addr  = wr_addr;
  assign pass_data  = wr_data;

endmodule

// File: rtl/wsync_land.sv
// Timer-side half: detects a new request toggle, emits one pulse and
// returns the toggle as the acknowledge.
module wsync_land #(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tog,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  output logic          tm_valid,
  output logic [AW-1:0] tm_addr,
  output logic [DW-1:0] tm_data,
  output logic          ack_tog
);

  logic req_s;
  logic seen_q;

  wsync_tog_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tog),
    .q     (req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= req_s;
  end

  // The held bus registers are quiet while the toggle is in flight, so
  // they can be sampled directly by the timer-side decode.
  assign tm_valid = req_s ^ seen_q;
  assign tm_addr  = hold_addr;
  assign tm_data  = hold_data;
  assign ack_tog  = seen_q;

endmodule

// File: rtl/wsync_xdom.sv
module wsync_xdom #(
  parameter int unsigned AW     = wsync_pkg::DEF_AW,
  parameter int unsigned DW     = wsync_pkg::DEF_DW,
  parameter int unsigned STAGES = wsync_pkg::DEF_STAGES,
  parameter logic [(1<<AW)-1:0] COVER = wsync_pkg::DEF_COVER
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          pass_valid,
  output logic [AW-1:0] pass_addr,
  output logic [DW-1:0] pass_data,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  output logic          tm_valid,
  output logic [AW-1:0] tm_addr,
  output logic [DW-1:0] tm_data
);

  logic          req_tog;
  logic          ack_tog;
  logic          ack_sync;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  wsync_launch #(.AW(AW), .DW(DW), .COVER(COVER)) u_launch (
    .clk        (bus_clk),
    .rst_n      (bus_rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ack_sync   (ack_sync),
    .busy       (busy),
    .req_tog    (req_tog),
    .hold_addr  (hold_addr),
    .hold_data  (hold_data),
    .pass_valid (pass_valid),
    .pass_addr  (pass_addr),
    .pass_data  (pass_data)
  );

  wsync_land #(.AW(AW), .DW(DW), .STAGES(STAGES)) u_land (
    .clk       (tmr_clk),
    .rst_n     (tmr_rst_n),
    .req_tog   (req_tog),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .tm_valid  (tm_valid),
    .tm_addr   (tm_addr),
    .tm_data   (tm_data),
    .ack_tog   (ack_tog)
  );

  // Acknowledge returns through its own bus-side synchronizer.
  wsync_tog_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tog),
    .q     (ack_sync)
  );

endmodule

// File: rtl/wsync_xdom_chk.sv
module wsync_xdom_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter logic [(1<<AW)-1:0] COVER = '1
) (
  input logic          bus_clk,
  input logic          bus_rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          tmr_clk,
  input logic          tmr_rst_n,
  input logic          tm_valid,
  input logic [AW-1:0] tm_addr,
  input logic [DW-1:0] tm_data
);

  assert_idle_after_reset_R1: assert property (@(posedge bus_clk)
    disable iff (!bus_rst_n) $rose(bus_rst_n) |-> !busy);

  assert_busy_set_R2: assert property (@(posedge bus_clk)
    disable iff (!bus_rst_n) (wr_en && COVER[wr_addr] && !busy) |=> busy);

  assert_hold_stable_R3: assert property (@(posedge bus_clk)
    disable iff (!bus_rst_n) (busy && $past(busy)) |-> ($stable(tm_addr) && $stable(tm_data)));

  assert_single_pulse_R4: assert property (@(posedge tmr_clk)
    disable iff (!tmr_rst_n) tm_valid |=> !tm_valid);

  assert_pulse_in_busy_R6: assert property (@(posedge tmr_clk)
    disable iff (!tmr_rst_n || !bus_rst_n) tm_valid |-> busy);

  assert_pass_no_busy_R7: assert property (@(posedge bus_clk)
    disable iff (!bus_rst_n) (!busy && wr_en && !COVER[wr_addr]) |=> !busy);

endmodule

bind wsync_xdom wsync_xdom_chk #(.AW(AW), .DW(DW), .COVER(COVER)) u_chk (
  .bus_clk   (bus_clk),
  .bus_rst_n (bus_rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .busy      (busy),
  .tmr_clk   (tmr_clk),
  .tmr_rst_n (tmr_rst_n),
  .tm_valid  (tm_valid),
  .tm_addr   (tm_addr),
  .tm_data   (tm_data)
);

// File: tb/sim_wsync_xdom.sv
module sim_wsync_xdom;

  localparam int CLK_PERIOD  = 10;
  localparam int TCLK_PERIOD = 24;
  localparam int AW     = 4;
  localparam int DW     = 32;
  localparam int STAGES = 2;
  localparam logic [15:0] COVER = 16'h07FF;  // R8: addresses 0..10 covered
  localparam int BUSY_MIN = STAGES + 1;
  localparam int BUSY_MAX = ((STAGES + 1) * TCLK_PERIOD) / CLK_PERIOD + STAGES + 3;

  logic          bus_clk = 1'b0;
  logic          tmr_clk = 1'b0;
  logic          bus_rst_n = 1'b0;
  logic          tmr_rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy, pass_valid, tm_valid;
  logic [AW-1:0] pass_addr, tm_addr;
  logic [DW-1:0] pass_data, tm_data;

  always #(CLK_PERIOD/2)  bus_clk = ~bus_clk;
  always #(TCLK_PERIOD/2) tmr_clk = ~tmr_clk;

  wsync_xdom #(.AW(AW), .DW(DW), .STAGES(STAGES), .COVER(COVER)) u0 (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .pass_valid(pass_valid), .pass_addr(pass_addr),
    .pass_data(pass_data), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
    .tm_valid(tm_valid), .tm_addr(tm_addr), .tm_data(tm_data)
  );

  int nt = 0, nf = 0;
  int mon_nt = 0, mon_nf = 0;
  int tcnt = 0, t_at_wr = 0;
  int pulses = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always @(posedge tmr_clk) tcnt <= tcnt + 1;

  // Timestamp of each accepted write (R2 acceptance rule), in timer edges.
  always @(posedge bus_clk)
    if (bus_rst_n && wr_en && !busy && COVER[wr_addr]) t_at_wr <= tcnt;

  // Timer-side monitor, sampled at the falling timer edge.
  always @(negedge tmr_clk) begin
    if (tmr_rst_n && tm_valid) begin
      pulses <= pulses + 1;
      last_addr <= tm_addr;
      last_data <= tm_data;
      mon_nt++;
      if (tcnt - t_at_wr != STAGES) begin
        mon_nf++;
        $display("FAIL R5 pulse latency actual=%0d expected=%0d", tcnt - t_at_wr, STAGES);
      end
      mon_nt++;
      if (prev_valid) begin
        mon_nf++;
        $display("FAIL R4 pulse width actual=2+ expected=1");
      end
    end
    prev_valid <= tm_valid;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nt++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cov_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0;
    int n;
    logic [AW-1:0] ua;
    @(negedge bus_clk);
    c0 = pulses;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 chk("R7 covered write not bypassed", 64'(pass_valid), 64'd0);
    @(negedge bus_clk);
    chk("R2 busy after accept", 64'(busy), 64'd1);
    // discarded covered write to a neighbouring covered register
    wr_addr = AW'((a + 1) % 11); wr_data = ~d;
    #1 chk("R3 dropped write not bypassed", 64'(pass_valid), 64'd0);
    @(negedge bus_clk);
    // uncovered write while busy passes straight through
    ua = AW'(11 + (a % 5));
    wr_addr = ua; wr_data = d ^ 32'h5A5A_0F0F;
    #1 begin
      chk("R7 bypass valid while busy", 64'(pass_valid), 64'd1);
      chk("R7 bypass addr", 64'(pass_addr), 64'(ua));
      chk("R7 bypass data", 64'(pass_data), 64'(d ^ 32'h5A5A_0F0F));
    end
    @(negedge bus_clk);
    wr_en = 1'b0;
    chk("R3 still busy during drops", 64'(busy), 64'd1);
    n = 3;
    while (busy && n < 100) begin
      @(negedge bus_clk);
      n++;
    end
    chk("R6 busy period in window", 64'((n >= BUSY_MIN) && (n <= BUSY_MAX)), 64'd1);
    chk("R6 pulse before busy fell", 64'(pulses), 64'(c0 + 1));
    repeat (6) @(negedge bus_clk);
    chk("R4 exactly one pulse", 64'(pulses), 64'(c0 + 1));
    chk("R4 delivered addr", 64'(last_addr), 64'(a));
    chk("R3 delivered data is first write", 64'(last_data), 64'(d));
  endtask

  task automatic unc_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0;
    @(negedge bus_clk);
    c0 = pulses;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 begin
      chk("R7 bypass valid", 64'(pass_valid), 64'd1);
      chk("R7 bypass data", 64'(pass_data), 64'(d));
    end
    @(negedge bus_clk);
    wr_en = 1'b0;
    chk("R7 no busy from uncovered", 64'(busy), 64'd0);
    repeat (8) @(negedge bus_clk);
    chk("R8 uncovered gives no pulse", 64'(pulses), 64'(c0));
  endtask

  initial begin
    repeat (3) @(negedge bus_clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 tm_valid in reset", 64'(tm_valid), 64'd0);
    chk("R1 pass_valid in reset", 64'(pass_valid), 64'd0);
    bus_rst_n = 1'b1;
    tmr_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 no pulse after reset", 64'(pulses), 64'd0);
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        logic [DW-1:0] d;
        d = DW'(a) * 32'h0100_0193 + DW'(pass + 1) * 32'h9E37_79B9;
        if (COVER[a]) cov_write(AW'(a), d);
        else          unc_write(AW'(a), d);
      end
    end
    repeat (10) @(negedge bus_clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nt + mon_nt, nf + mon_nf);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bus_clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nt + mon_nt + 1, nf + mon_nf + 1);
      $finish;
    end
  end

endmodule